// File: doc/BRIEF.md
# ISA Byte-Lane Steering Unit

This block sits between the 16-bit ISA data bus and a slave device's 16-bit internal register port. For every I/O cycle aimed at the device it classifies the access from the low address bit and the active-low byte-high-enable. It then decides which data lanes the device drives on reads and which internal bytes take data on writes. When the cycle cannot be 16 bits wide, a swap path moves odd-byte data between the low bus lane and the high internal byte. This happens either because the device has no 16-bit decode for the address or because a configuration bit forces byte-only operation.

Reads drive the bus only while the read strobe is low. Writes produce a one-cycle byte-enable pulse toward the register file after the write strobe falls. The one address/enable combination the bus never allows raises a one-cycle flag, and that cycle moves no data. Address decoding and wait-state insertion are done elsewhere.

Top module: `isa_lane_steer`

## Requirements
- R1: With `a0`=0 and `hi_en_n`=0 in a 16-bit cycle (`io16_n`=0), a read drives both lanes with `sd_out`=`reg_rdata`, and a write pulses `reg_wbe`=2'b11 with `reg_wdata`=`sd_in`.
- R2: With `a0`=0 and `hi_en_n`=1, a read drives only the low lane with `sd_out[7:0]`=`reg_rdata[7:0]`, and a write pulses `reg_wbe`=2'b01 (bit 0 is the low internal byte) with `reg_wdata[7:0]`=`sd_in[7:0]`.
- R3: With `a0`=1 and `hi_en_n`=0 in a 16-bit cycle, a read drives only the high lane with `sd_out[15:8]`=`reg_rdata[15:8]`, and a write pulses `reg_wbe`=2'b10 with `reg_wdata[15:8]`=`sd_in[15:8]`.
- R4: An odd-byte read in an 8-bit cycle drives only the low lane and places `reg_rdata[15:8]` on `sd_out[7:0]`. During it, `swap_en` is high and the high lane stays undriven.
- R5: An odd-byte write in an 8-bit cycle delivers `sd_in[7:0]` to `reg_wdata[15:8]` with `reg_wbe`=2'b10, and `swap_en` is high for that pulse.
- R6: A word request (`a0`=0, `hi_en_n`=0) in an 8-bit cycle is carried out as a low-byte-only transfer, exactly as in R2.
- R7: `io16_n` is low only when `cap16`=1 and `cfg_byte_only`=0. With `cfg_byte_only`=1 every cycle is 8-bit, and the high lane is never driven.
- R8: `a0`=1 with `hi_en_n`=1 is illegal. On either strobe falling, `illegal` pulses for exactly one cycle, no lane is driven, and `reg_wbe` stays 0.
- R9: Lane enables become active in the cycle after the clock edge that first samples `rd_n` low. They drop in the same cycle that `rd_n` returns high, with no clock edge in between.
- R10: `reg_wbe` is non-zero for exactly one cycle, the cycle after the clock edge that sees `wr_n` fall.
- R11: During and right after reset, `sd_oe_lo`, `sd_oe_hi`, `swap_en`, `illegal` and `reg_wbe` are all inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a0 | input | 1 | Bus address bit 0 |
| hi_en_n | input | 1 | Byte-high-enable from the bus, active low |
| rd_n | input | 1 | I/O read strobe, active low |
| wr_n | input | 1 | I/O write strobe, active low |
| cap16 | input | 1 | Device has 16-bit decode for the current address |
| cfg_byte_only | input | 1 | Forces 8-bit-only operation |
| sd_in | input | 16 | Data bus value seen by the device |
| sd_out | output | 16 | Data the device presents on the bus |
| sd_oe_lo | output | 1 | Drive enable for bus lane 7:0 |
| sd_oe_hi | output | 1 | Drive enable for bus lane 15:8 |
| io16_n | output | 1 | 16-bit cycle select toward the bus, active low |
| swap_en | output | 1 | Swap path in use (odd byte via low lane) |
| reg_rdata | input | 16 | Internal register read data |
| reg_wdata | output | 16 | Internal register write data |
| reg_wbe | output | 2 | Internal byte write enables, bit 0 low byte |
| illegal | output | 1 | One-cycle pulse on an illegal access |

## Verification
The bound assertions check, on every cycle, the properties that need no scenario: a write-enable pulse lasts one cycle and follows a low write strobe, an illegal pulse never coincides with lane drive or write enables, the swap path excludes the high lane, and byte-only configuration keeps the high lane off. Only the bench's scenarios can show the data routing. That means which internal byte lands on which lane for each of the four address/enable codes, with and without 16-bit select. The bench also checks the exact cycle a lane enable appears and its release at the strobe's rising edge.

// File: rtl/isa_lane_pkg.sv
package isa_lane_pkg;
    localparam int LANE_W = 8;
    localparam int NUM_LANES = 2;
    localparam int DATA_W = LANE_W * NUM_LANES;

    typedef enum logic [2:0] {
        ACC_WORD,   // both lanes, direct
        ACC_LOW,    // low lane, low internal byte
        ACC_HIGH,   // high lane, high internal byte
        ACC_SWAP,   // low lane carries high internal byte
        ACC_BAD     // illegal address/enable pair
    } acc_e;

    typedef struct packed {
        logic                 rd_prev;
        logic                 wr_prev;
        logic                 oe_lo;
        logic                 oe_hi;
        logic                 rd_swap;
        logic                 wr_swap;
        logic                 illegal;
        logic [NUM_LANES-1:0] wbe;
        logic [DATA_W-1:0]    wdata;
    } lane_state_t;
endpackage

// File: rtl/isa_lane_decode.sv
module isa_lane_decode
    import isa_lane_pkg::*;
(
    input  logic a0,
    input  logic hi_en_n,
    input  logic wide_ok,
    output acc_e kind
);
    always_comb begin
        unique case ({a0, hi_en_n})
            2'b00:   kind = wide_ok ? ACC_WORD : ACC_LOW;
            2'b01:   kind = ACC_LOW;
            2'b10:   kind = wide_ok ? ACC_HIGH : ACC_SWAP;
            default: kind = ACC_BAD;
        endcase
    end
endmodule

// File: rtl/isa_lane_rdmux.sv
module isa_lane_rdmux
    import isa_lane_pkg::*;
(
    input  acc_e              kind,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] bus_data,
    output logic              want_lo,
    output logic              want_hi,
    output logic              swap
);
    localparam int HI = LANE_W;

    always_comb begin
        swap    = (kind == ACC_SWAP);
        want_lo = (kind == ACC_WORD) || (kind == ACC_LOW) || (kind == ACC_SWAP);
        want_hi = (kind == ACC_WORD) || (kind == ACC_HIGH);
    end

    // high lane always presents the high internal byte
    assign bus_data[HI +: LANE_W] = rdata[HI +: LANE_W];
    // low lane picks the swapped byte on odd 8-bit reads
    assign bus_data[0 +: LANE_W]  = swap ? rdata[HI +: LANE_W] : rdata[0 +: LANE_W];
endmodule

// File: rtl/isa_lane_wrmux.sv
module isa_lane_wrmux
    import isa_lane_pkg::*;
(
    input  acc_e                 kind,
    input  logic [DATA_W-1:0]    bus_data,
    output logic [DATA_W-1:0]    wdata,
    output logic [NUM_LANES-1:0] wbe,
    output logic                 swap
);
    localparam int HI = LANE_W;

    always_comb begin
        swap = (kind == ACC_SWAP);
        unique case (kind)
            ACC_WORD: wbe = 2'b11;
            ACC_LOW:  wbe = 2'b01;
            ACC_HIGH: wbe = 2'b10;
            ACC_SWAP: wbe = 2'b10;
            default:  wbe = 2'b00;
        endcase
    end

    assign wdata[0 +: LANE_W]  = bus_data[0 +: LANE_W];
    assign wdata[HI +: LANE_W] = swap ? bus_data[0 +: LANE_W] : bus_data[HI +: LANE_W];
endmodule

// File: rtl/isa_lane_steer.sv
module isa_lane_steer
    import isa_lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a0,
    input  logic              hi_en_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              cap16,
    input  logic              cfg_byte_only,
    input  logic [DATA_W-1:0] sd_in,
    output logic [DATA_W-1:0] sd_out,
    output logic              sd_oe_lo,
    output logic              sd_oe_hi,
    output logic              io16_n,
    output logic              swap_en,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] reg_wdata,
    output logic [1:0]        reg_wbe,
    output logic              illegal
);
    localparam lane_state_t RESET_STATE = '{
        rd_prev: 1'b1, wr_prev: 1'b1, oe_lo: 1'b0, oe_hi: 1'b0,
        rd_swap: 1'b0, wr_swap: 1'b0, illegal: 1'b0,
        wbe: '0, wdata: '0
    };

    lane_state_t st_d, st_q;

    logic                 wide_ok;
    acc_e                 kind;
    logic [DATA_W-1:0]    rd_bus;
    logic                 rd_want_lo, rd_want_hi, rd_swap_c;
    logic [DATA_W-1:0]    wr_data_c;
    logic [NUM_LANES-1:0] wr_be_c;
    logic                 wr_swap_c;

    // byte-only configuration suppresses the 16-bit select
    assign wide_ok = cap16 & ~cfg_byte_only;

    isa_lane_decode u_decode (
        .a0      (a0),
        .hi_en_n (hi_en_n),
        .wide_ok (wide_ok),
        .kind    (kind)
    );

    isa_lane_rdmux u_rdmux (
        .kind     (kind),
        .rdata    (reg_rdata),
        .bus_data (rd_bus),
        .want_lo  (rd_want_lo),
        .want_hi  (rd_want_hi),
        .swap     (rd_swap_c)
    );

    isa_lane_wrmux u_wrmux (
        .kind     (kind),
        .bus_data (sd_in),
        .wdata    (wr_data_c),
        .wbe      (wr_be_c),
        .swap     (wr_swap_c)
    );

    always_comb begin
        logic rd_act, rd_start, wr_start;
        rd_act   = ~rd_n;
        rd_start = ~rd_n & st_q.rd_prev;
        wr_start = ~wr_n & st_q.wr_prev;

        st_d         = st_q;
        st_d.rd_prev = rd_n;
        st_d.wr_prev = wr_n;
        st_d.oe_lo   = rd_act & rd_want_lo;
        st_d.oe_hi   = rd_act & rd_want_hi;
        st_d.rd_swap = rd_act & rd_swap_c;
        st_d.wbe     = wr_start ? wr_be_c : '0;
        st_d.wr_swap = wr_start & wr_swap_c;
        st_d.illegal = (rd_start | wr_start) & (kind == ACC_BAD);
        if (wr_start) begin
            st_d.wdata = wr_data_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    // registered enables are released combinationally by the strobe
    assign sd_oe_lo  = st_q.oe_lo & ~rd_n;
    assign sd_oe_hi  = st_q.oe_hi & ~rd_n;
    assign swap_en   = (st_q.rd_swap & ~rd_n) | st_q.wr_swap;
    assign sd_out    = rd_bus;
    assign io16_n    = ~wide_ok;
    assign reg_wdata = st_q.wdata;
    assign reg_wbe   = st_q.wbe;
    assign illegal   = st_q.illegal;
endmodule

// File: rtl/isa_lane_steer_chk.sv
module isa_lane_steer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_n,
    input logic       cfg_byte_only,
    input logic       sd_oe_lo,
    input logic       sd_oe_hi,
    input logic       swap_en,
    input logic [1:0] reg_wbe,
    input logic       illegal
);
    // R10
    wbe_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wbe != 2'b00) |=> (reg_wbe == 2'b00));

    // R10
    wbe_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wbe != 2'b00) |-> $past(!wr_n));

    // R8
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (reg_wbe == 2'b00) && !sd_oe_lo && !sd_oe_hi);

    // R8
    illegal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> !illegal);

    // R4
    swap_excl_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_en |-> !sd_oe_hi);

    // R7
    byte_only_hi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_byte_only && $past(cfg_byte_only)) |-> !sd_oe_hi);
endmodule

bind isa_lane_steer isa_lane_steer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_n          (wr_n),
    .cfg_byte_only (cfg_byte_only),
    .sd_oe_lo      (sd_oe_lo),
    .sd_oe_hi      (sd_oe_hi),
    .swap_en       (swap_en),
    .reg_wbe       (reg_wbe),
    .illegal       (illegal)
);

// File: tb/isa_lane_steer_test.sv
`timescale 1ns/1ps
module isa_lane_steer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a0 = 1'b0, hi_en_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic        cap16 = 1'b0, cfg_byte_only = 1'b0;
    logic [15:0] sd_in = '0, reg_rdata = '0;
    logic [15:0] sd_out, reg_wdata;
    logic        sd_oe_lo, sd_oe_hi, io16_n, swap_en, illegal;
    logic [1:0]  reg_wbe;

    int n_tests = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    isa_lane_steer uut (.*);

    typedef struct {
        int          due;
        int          kind;   // 0 read data, 1 write data, 2 quiet after
        logic        oe_lo, oe_hi, swap, ill, io16n;
        logic [15:0] dout;
        logic [1:0]  wbe;
        logic [15:0] wdata;
        string       tag;
    } item_t;

    item_t sb[$];

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // expected behaviour derived from the requirement text
    task automatic expect_for(input logic ea0, input logic ehen, input logic ecap, input logic ecfg,
                              input logic [15:0] rdat, input logic [15:0] wdat, output item_t it);
        logic wide;
        wide = ecap & ~ecfg;
        it.io16n = ~wide;
        it.ill = 0; it.swap = 0; it.oe_lo = 0; it.oe_hi = 0; it.wbe = 2'b00;
        it.dout = 'x; it.wdata = 'x;
        if (ea0 && ehen) begin
            it.ill = 1;
        end else if (!ea0 && !ehen && wide) begin
            it.oe_lo = 1; it.oe_hi = 1; it.dout = rdat; it.wbe = 2'b11; it.wdata = wdat;
        end else if (!ea0) begin
            it.oe_lo = 1; it.dout = {8'h00, rdat[7:0]}; it.wbe = 2'b01; it.wdata = {8'h00, wdat[7:0]};
        end else if (wide) begin
            it.oe_hi = 1; it.dout = {rdat[15:8], 8'h00}; it.wbe = 2'b10; it.wdata = {wdat[15:8], 8'h00};
        end else begin
            it.swap = 1; it.oe_lo = 1; it.dout = {8'h00, rdat[15:8]}; it.wbe = 2'b10;
            it.wdata = {wdat[7:0], 8'h00};
        end
    endtask

    task automatic do_cycle(input bit is_wr, input logic ea0, input logic ehen, input logic ecap,
                            input logic ecfg, input logic [15:0] dat, input string tag);
        item_t it, q;
        @(negedge clk);
        a0 = ea0; hi_en_n = ehen; cap16 = ecap; cfg_byte_only = ecfg;
        if (is_wr) begin sd_in = dat; reg_rdata = 16'h0; wr_n = 0; end
        else begin reg_rdata = dat; sd_in = 16'h0; rd_n = 0; end
        expect_for(ea0, ehen, ecap, ecfg, dat, dat, it);
        it.due = cyc + 1; it.kind = is_wr ? 1 : 0; it.tag = tag;
        sb.push_back(it);
        q = it; q.due = cyc + 2; q.kind = 2;
        sb.push_back(q);
        @(negedge clk);
        @(negedge clk);
        rd_n = 1; wr_n = 1;
        @(negedge clk);
    endtask

    // monitor: pops expected items as their cycle comes up
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0 && sb[0].due == cyc) begin
                item_t e;
                e = sb.pop_front();
                if (e.kind == 0) begin
                    chk(sd_oe_lo == e.oe_lo, e.tag, "rd oe_lo", sd_oe_lo, e.oe_lo);
                    chk(sd_oe_hi == e.oe_hi, e.tag, "rd oe_hi", sd_oe_hi, e.oe_hi);
                    chk(swap_en == e.swap, e.tag, "rd swap", swap_en, e.swap);
                    chk(illegal == e.ill, e.tag, "rd illegal", illegal, e.ill);
                    chk(io16_n == e.io16n, e.tag, "io16_n", io16_n, e.io16n);
                    if (e.oe_lo) chk(sd_out[7:0] == e.dout[7:0], e.tag, "low lane", sd_out[7:0], e.dout[7:0]);
                    if (e.oe_hi) chk(sd_out[15:8] == e.dout[15:8], e.tag, "high lane", sd_out[15:8], e.dout[15:8]);
                end else if (e.kind == 1) begin
                    chk(reg_wbe == e.wbe, e.tag, "wbe", reg_wbe, e.wbe);
                    chk(swap_en == e.swap, e.tag, "wr swap", swap_en, e.swap);
                    chk(illegal == e.ill, e.tag, "wr illegal", illegal, e.ill);
                    if (e.wbe[0]) chk(reg_wdata[7:0] == e.wdata[7:0], e.tag, "wdata lo", reg_wdata[7:0], e.wdata[7:0]);
                    if (e.wbe[1]) chk(reg_wdata[15:8] == e.wdata[15:8], e.tag, "wdata hi", reg_wdata[15:8], e.wdata[15:8]);
                end else begin
                    // R9 release at strobe rise, R10/R8 single-cycle pulses
                    chk(!sd_oe_lo && !sd_oe_hi, {e.tag, "/R9"}, "release", {sd_oe_hi, sd_oe_lo}, 0);
                    chk(reg_wbe == 2'b00, {e.tag, "/R10"}, "wbe pulse end", reg_wbe, 0);
                    chk(!illegal, {e.tag, "/R8"}, "illegal pulse end", illegal, 0);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", sb.size(), 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R11 reset state
        repeat (3) @(negedge clk);
        chk(!sd_oe_lo && !sd_oe_hi && !swap_en && !illegal && reg_wbe == 0, "R11", "in reset",
            {sd_oe_lo, sd_oe_hi, swap_en, illegal, reg_wbe}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!sd_oe_lo && !sd_oe_hi && !swap_en && !illegal && reg_wbe == 0, "R11", "after reset",
            {sd_oe_lo, sd_oe_hi, swap_en, illegal, reg_wbe}, 0);

        // R9 enable not visible before the sampling edge
        @(negedge clk);
        a0 = 0; hi_en_n = 0; cap16 = 1; cfg_byte_only = 0; reg_rdata = 16'h1234; rd_n = 0;
        #1;
        chk(!sd_oe_lo && !sd_oe_hi, "R9", "before edge", {sd_oe_hi, sd_oe_lo}, 0);
        @(negedge clk);
        @(negedge clk);
        rd_n = 1;
        @(negedge clk);

        // reads
        do_cycle(0, 0, 0, 1, 0, 16'hA55A, "R1");
        do_cycle(0, 0, 1, 1, 0, 16'h3C7E, "R2");
        do_cycle(0, 0, 1, 0, 0, 16'h0F1E, "R2");
        do_cycle(0, 1, 0, 1, 0, 16'hBEEF, "R3");
        do_cycle(0, 1, 0, 0, 0, 16'hC3D4, "R4");
        do_cycle(0, 0, 0, 0, 0, 16'h7788, "R6");
        do_cycle(0, 0, 0, 1, 1, 16'h99AA, "R7");
        do_cycle(0, 1, 0, 1, 1, 16'hE15B, "R7");
        do_cycle(0, 1, 1, 1, 0, 16'hFFFF, "R8");
        // writes
        do_cycle(1, 0, 0, 1, 0, 16'h1357, "R1");
        do_cycle(1, 0, 1, 0, 0, 16'h2468, "R2");
        do_cycle(1, 1, 0, 1, 0, 16'hFACE, "R3");
        do_cycle(1, 1, 0, 0, 0, 16'h00A7, "R5");
        do_cycle(1, 0, 0, 0, 0, 16'h5AA5, "R6");
        do_cycle(1, 1, 0, 1, 1, 16'h6B1C, "R7");
        do_cycle(1, 1, 1, 0, 0, 16'h4242, "R8");
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R10", "scoreboard drained", sb.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule